// File: doc/BRIEF.md
# Configurable serial frame transmitter

This block turns parallel words into a serial bit stream on a single output line. Software-side logic writes a word into a one-word holding register. The transmitter moves that word into its shift register at the next transmit clock and then sends it bit by bit. The framing is set by a handful of static control inputs: bit timing of one or sixteen transmit clocks per bit, a word length of 5 to 8 bits, an optional parity bit of either sense, and a framing mode. The mode is either synchronous (bare data bits) or asynchronous, with a low start bit and 1, 1.5 or 2 high stop bits.

When the holding register runs dry, the line behaves differently in the two framings. In asynchronous framing it rests at the marking (high) level. In synchronous framing it keeps sending a stored sync character, so the receiver never loses bit alignment. The transmit clock reaches the block as a one-cycle enable pulse in the system clock domain.

Top module: `frame_tx`

## Requirements
- R1: With `cfg_div16` = 0, each frame bit is held on `txd` for exactly one `tx_tick` pulse. The bit changes on the system clock edge that samples the pulse, and `txd` never changes in a cycle that follows a cycle without a pulse.
- R2: With `cfg_div16` = 1, each frame bit lasts exactly 16 `tx_tick` pulses.
- R3: `cfg_wlen` selects the number of data bits: 00 gives 8, 01 gives 7, 10 gives 6 and 11 gives 5. Data bits go out least significant bit first, starting from `wr_data[0]`.
- R4: `cfg_fmt` selects the framing. 00 sends data (and parity) only. 01 sends a low start bit and one high stop bit. 10 sends a start bit and 1.5 stop bits. 11 sends a start bit and two stop bits.
- R5: With `cfg_par_en` = 1, one parity bit follows the last data bit. With `cfg_par_even` = 1, that bit makes the total number of ones over data and parity even. With `cfg_par_even` = 0, it makes the total odd.
- R6: In format 10 with `cfg_div16` = 1, the stop period lasts 24 `tx_tick` pulses. With `cfg_div16` = 0, format 10 sends two full stop bits.
- R7: In asynchronous framing, when the holding register is empty at the end of a frame, `txd` stays high until a new word is written and a tick loads it.
- R8: In synchronous framing, when the holding register is empty at a frame boundary, `sync_char` is sent in place of data. If parity is enabled, its parity bit is computed for 8-bit words. For shorter words, the parity bit is `sync_char` bit N, where N is the word length.
- R9: `hold_empty` rises in the cycle after a word moves into the shift register. It falls in the cycle after `wr_en`, and a write in the same cycle as a move takes precedence.
- R10: After reset, `txd` is high and `hold_empty` is high.
- R11: When a word is waiting at the end of the last stop bit (or the last bit in synchronous framing), the next frame's first bit follows at once, with no idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_tick | input | 1 | One-cycle pulse per transmit clock |
| cfg_div16 | input | 1 | 1: sixteen ticks per bit, 0: one tick per bit |
| cfg_wlen | input | 2 | Word length code (00=8 … 11=5) |
| cfg_fmt | input | 2 | Framing code (00 sync, 01/10/11 async with 1/1.5/2 stops) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| sync_char | input | DATA_W | Fill character for synchronous underrun |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to transmit |
| hold_empty | output | 1 | Holding register may accept a new word |
| txd | output | 1 | Serial output line |

## Verification
A wrong bit counter or shift register shows at once on `txd`. The bit sequence is compared against a model at every tick, so a misplaced parity, stop or start bit shows within one bit period of where it should appear. A wrong cell count appears as a shifted edge: a bad 1.5-stop length moves the next frame's start bit by at least one tick. It is therefore checked with a second word queued directly behind the first. A stale holding-register flag shows on `hold_empty` one clock after the write or load. In synchronous mode it also shows as a sync character where data was expected.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef enum logic [1:0] {
    FMT_SYNC   = 2'b00,
    FMT_STOP1  = 2'b01,
    FMT_STOP15 = 2'b10,
    FMT_STOP2  = 2'b11
  } fmt_e;

  function automatic logic fmt_is_async(input logic [1:0] f);
    return f != FMT_SYNC;
  endfunction

endpackage

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] word,
  output logic              empty
);

  logic [DATA_W-1:0] word_q, word_d;
  logic              empty_q, empty_d;

  always_comb begin
    word_d  = word_q;
    empty_d = empty_q;
    if (wr_en) begin
      word_d  = wr_data;
      empty_d = 1'b0;
    end else if (take) begin
      empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      word_q  <= word_d;
      empty_q <= empty_d;
    end
  end

  assign word  = word_q;
  assign empty = empty_q;

endmodule

// File: rtl/frame_tx_build.sv
module frame_tx_build #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  word,
  input  logic [DATA_W-1:0]  sync_char,
  input  logic               use_sync,
  input  logic [1:0]         wlen,
  input  logic [1:0]         fmt,
  input  logic               par_en,
  input  logic               par_even,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   flen
);
  import frame_tx_pkg::*;

  logic [DATA_W-1:0]  src, mask, data_m;
  logic [LEN_W-1:0]   nbits, n_start, n_body, n_stop;
  logic               calc_par, stored_par, par_bit;
  logic [FRAME_W-1:0] body;

  always_comb begin
    src        = use_sync ? sync_char : word;
    nbits      = LEN_W'(DATA_W) - LEN_W'(wlen);
    mask       = ~({DATA_W{1'b1}} << nbits);
    data_m     = src & mask;
    calc_par   = par_even ? (^data_m) : ~(^data_m);
    stored_par = |((src >> nbits) & DATA_W'(1));
    par_bit    = (use_sync && (nbits != LEN_W'(DATA_W))) ? stored_par : calc_par;

    n_start = fmt_is_async(fmt) ? LEN_W'(1) : LEN_W'(0);
    n_body  = nbits + LEN_W'(par_en);
    case (fmt)
      FMT_SYNC:  n_stop = LEN_W'(0);
      FMT_STOP1: n_stop = LEN_W'(1);
      default:   n_stop = LEN_W'(2);
    endcase

    body  = FRAME_W'(data_m) | (FRAME_W'(par_en & par_bit) << nbits);
    frame = ({FRAME_W{1'b1}} << (n_start + n_body)) | (body << n_start);
    flen  = n_start + n_body + n_stop;
  end

endmodule

// File: rtl/frame_tx_cell.sv
module frame_tx_cell #(
  parameter int CELLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clr,
  input  logic div16,
  input  logic short_bit,
  output logic bit_end
);

  localparam int CELL_W = $clog2(CELLS);

  logic [CELL_W-1:0] cnt_q, cnt_d, lim;
  logic              step;

  always_comb begin
    lim     = short_bit ? CELL_W'(CELLS / 2 - 1) : CELL_W'(CELLS - 1);
    step    = tick & run;
    bit_end = step & (~div16 | (cnt_q == lim));
    if (clr || bit_end)
      cnt_d = '0;
    else if (step && div16)
      cnt_d = cnt_q + CELL_W'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift #(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               bit_end,
  input  logic               start_ok,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   flen_in,
  input  logic               half_in,
  output logic               load,
  output logic               busy,
  output logic               short_bit,
  output logic               txd
);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic               busy_q, busy_d;
  logic               half_q, half_d;
  logic               txd_q, txd_d;
  logic               last;

  always_comb begin
    last   = busy_q && (left_q == LEN_W'(1));
    load   = tick & start_ok & (~busy_q | (bit_end & last));
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    half_d = half_q;
    if (load) begin
      sh_d   = frame_in;
      left_d = flen_in;
      busy_d = 1'b1;
      half_d = half_in;
    end else if (bit_end) begin
      if (last) begin
        busy_d = 1'b0;
      end else begin
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        left_d = left_q - LEN_W'(1);
      end
    end
    txd_d = busy_d ? sh_d[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      half_q <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
      half_q <= half_d;
      txd_q  <= txd_d;
    end
  end

  assign busy      = busy_q;
  assign short_bit = last & half_q;
  assign txd       = txd_q;

endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int DATA_W = 8,
  parameter int CELLS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_tick,
  input  logic              cfg_div16,
  input  logic [1:0]        cfg_wlen,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [DATA_W-1:0] sync_char,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hold_empty,
  output logic              txd
);
  import frame_tx_pkg::*;

  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  held_word;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   flen;
  logic               load, busy, short_bit, bit_end, start_ok, half_stop;

  assign start_ok  = ~hold_empty | (cfg_fmt == FMT_SYNC);
  assign half_stop = cfg_div16 & (cfg_fmt == FMT_STOP15);

  frame_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load),
    .word    (held_word),
    .empty   (hold_empty)
  );

  frame_tx_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_build (
    .word      (held_word),
    .sync_char (sync_char),
    .use_sync  (hold_empty),
    .wlen      (cfg_wlen),
    .fmt       (cfg_fmt),
    .par_en    (cfg_par_en),
    .par_even  (cfg_par_even),
    .frame     (frame),
    .flen      (flen)
  );

  frame_tx_cell #(.CELLS(CELLS)) u_cell (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tx_tick),
    .run       (busy),
    .clr       (load),
    .div16     (cfg_div16),
    .short_bit (short_bit),
    .bit_end   (bit_end)
  );

  frame_tx_shift #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tx_tick),
    .bit_end   (bit_end),
    .start_ok  (start_ok),
    .frame_in  (frame),
    .flen_in   (flen),
    .half_in   (half_stop),
    .load      (load),
    .busy      (busy),
    .short_bit (short_bit),
    .txd       (txd)
  );

endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_tick,
  input logic [1:0] cfg_fmt,
  input logic       wr_en,
  input logic       hold_empty,
  input logic       txd,
  input logic       busy,
  input logic       load
);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> hold_empty);

  assert_idle_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_tick_paced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_tick |=> $stable(txd));

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_fmt != 2'b00) |=> !txd);

  assert_sync_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_tick && cfg_fmt == 2'b00) |=> busy);

endmodule

bind frame_tx frame_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_tick    (tx_tick),
  .cfg_fmt    (cfg_fmt),
  .wr_en      (wr_en),
  .hold_empty (hold_empty),
  .txd        (txd),
  .busy       (busy),
  .load       (load)
);

// File: tb/frame_tx_tb.sv
module frame_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_tick = 1'b0;
  logic       c_d16 = 1'b0;
  logic [1:0] c_wl = 2'b00;
  logic [1:0] c_fmt = 2'b01;
  logic       c_pe = 1'b0;
  logic       c_ev = 1'b0;
  logic [7:0] c_sync = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       hold_empty, txd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic exp_bits [0:1023];
  int   exp_n;

  always #5 clk = ~clk;

  frame_tx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_tick      (tx_tick),
    .cfg_div16    (c_d16),
    .cfg_wlen     (c_wl),
    .cfg_fmt      (c_fmt),
    .cfg_par_en   (c_pe),
    .cfg_par_even (c_ev),
    .sync_char    (c_sync),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .hold_empty   (hold_empty),
    .txd          (txd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic d16, input logic [1:0] wl, input logic [1:0] fmt,
                          input logic pe, input logic ev, input logic [7:0] sc);
    @(negedge clk);
    rst_n = 1'b0;
    c_d16 = d16; c_wl = wl; c_fmt = fmt; c_pe = pe; c_ev = ev; c_sync = sc;
    exp_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tx_tick = 1'b1;
    @(negedge clk);
    tx_tick = 1'b0;
  endtask

  task automatic push(input logic b, input int cells);
    for (int i = 0; i < cells; i++) begin
      exp_bits[exp_n] = b;
      exp_n++;
    end
  endtask

  // Expected frame from the requirements (R3, R4, R5, R6, R8)
  task automatic push_frame(input logic [7:0] d, input bit from_sync);
    int n;
    int cells;
    logic x;
    logic p;
    n = 8 - int'(c_wl);
    cells = c_d16 ? 16 : 1;
    x = 1'b0;
    for (int i = 0; i < n; i++) x = x ^ d[i];
    if (c_fmt != 2'b00) push(1'b0, cells);
    for (int i = 0; i < n; i++) push(d[i], cells);
    if (c_pe) begin
      if (from_sync && n < 8) p = d[n];
      else p = c_ev ? x : ~x;
      push(p, cells);
    end
    if (c_fmt != 2'b00) begin
      push(1'b1, cells);
      if (c_fmt == 2'b10) push(1'b1, c_d16 ? 8 : 1);
      else if (c_fmt == 2'b11) push(1'b1, cells);
    end
  endtask

  task automatic run_stream(input string req, input string what,
                            input int wr_at, input logic [7:0] wr_d);
    int first_bad;
    int a;
    int e;
    first_bad = -1; a = 0; e = 0;
    for (int i = 0; i < exp_n; i++) begin
      if (i == wr_at) write_word(wr_d);
      tick();
      if (txd !== exp_bits[i] && first_bad < 0) begin
        first_bad = i; a = int'(txd); e = int'(exp_bits[i]);
      end
    end
    check(first_bad < 0, req, $sformatf("%s bit-at-tick %0d", what, first_bad), a, e);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 8'h00);
    check(txd === 1'b1, "R10", "txd after reset", int'(txd), 1);
    check(hold_empty === 1'b1, "R10", "hold_empty after reset", int'(hold_empty), 1);
  endtask

  task automatic t_async_8n1();
    do_reset(1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 8'h00);
    write_word(8'hA5);
    push_frame(8'hA5, 0);
    push(1'b1, 4);
    run_stream("R1/R4/R7", "8N1 div1 then idle mark", -1, 8'h00);
  endtask

  task automatic t_async_7e1();
    do_reset(1'b0, 2'b01, 2'b01, 1'b1, 1'b1, 8'h00);
    write_word(8'hD3);
    push_frame(8'hD3, 0);
    push(1'b1, 2);
    run_stream("R3/R5", "7 bits even parity", -1, 8'h00);
  endtask

  task automatic t_async_5o2();
    do_reset(1'b0, 2'b11, 2'b11, 1'b1, 1'b0, 8'h00);
    write_word(8'hF6);
    push_frame(8'hF6, 0);
    push(1'b1, 2);
    run_stream("R3/R4/R5", "5 bits odd parity 2 stops", -1, 8'h00);
  endtask

  task automatic t_div16_6n1();
    do_reset(1'b1, 2'b10, 2'b01, 1'b0, 1'b0, 8'h00);
    write_word(8'h2D);
    push_frame(8'h2D, 0);
    push(1'b1, 20);
    run_stream("R2/R3", "div16 6 bits", -1, 8'h00);
  endtask

  task automatic t_div16_1p5();
    do_reset(1'b1, 2'b11, 2'b10, 1'b1, 1'b0, 8'h00);
    write_word(8'h13);
    push_frame(8'h13, 0);
    push_frame(8'h0C, 0);
    push(1'b1, 16);
    run_stream("R6/R11", "1.5 stop div16 back-to-back", 20, 8'h0C);
  endtask

  task automatic t_div1_1p5();
    do_reset(1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 8'h00);
    write_word(8'h55);
    push_frame(8'h55, 0);
    push_frame(8'h2A, 0);
    push(1'b1, 3);
    run_stream("R6/R11", "1.5 stop div1 acts as 2", 2, 8'h2A);
  endtask

  task automatic t_sync_8e();
    do_reset(1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 8'h96);
    push_frame(8'h96, 1);
    push_frame(8'h96, 1);
    push_frame(8'h3B, 0);
    push_frame(8'h96, 1);
    run_stream("R8/R11", "sync fill 8 bits computed parity", 12, 8'h3B);
  endtask

  task automatic t_sync_5o();
    do_reset(1'b0, 2'b11, 2'b00, 1'b1, 1'b0, 8'h0A);
    push_frame(8'h0A, 1);
    push_frame(8'h0A, 1);
    push_frame(8'h11, 0);
    push_frame(8'h0A, 1);
    run_stream("R8", "sync fill 5 bits stored parity", 8, 8'h11);
  endtask

  task automatic t_flag();
    do_reset(1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 8'h00);
    write_word(8'h81);
    check(hold_empty === 1'b0, "R9", "hold_empty after write", int'(hold_empty), 0);
    check(txd === 1'b1, "R7", "line before load tick", int'(txd), 1);
    tick();
    check(hold_empty === 1'b1, "R9", "hold_empty after load", int'(hold_empty), 1);
    check(txd === 1'b0, "R4", "start bit after load", int'(txd), 0);
  endtask

  initial begin
    t_reset();
    t_async_8n1();
    t_async_7e1();
    t_async_5o2();
    t_div16_6n1();
    t_div16_1p5();
    t_div1_1p5();
    t_sync_8e();
    t_sync_5o();
    t_flag();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule